// File: doc/BRIEF.md
# Zero-Flag Byte-Gated Word Store

This block is a small word-addressed store that skips storage work for zero bytes. Each 32-bit word is split into four byte lanes, and each lane keeps a one-bit flag that records whether its byte is all zero. On a write, a zero byte only sets its flag and leaves its storage cell alone. A nonzero byte clears the flag and is written. On a read, the flags are looked up with the data. A flagged lane returns zero without using its stored byte, and its output-drive enable stays low.

The block has a single write port with per-lane byte enables and a read port with one cycle of latency. A read returns the data word, a per-lane drive-enable mask and a valid strobe. Two saturating counters report how many byte writes and how many byte reads were suppressed. A downstream bus can use the drive mask to leave zero lanes undriven. The counters show how effective the compression is on real traffic.

Top module: `zero_gated_word_store`

## Requirements
- R1: On a write, each enabled lane whose byte (lane i = data bits 8i+7..8i) is all zero gets its flag set and its storage cell left unwritten. Each enabled nonzero lane gets its flag cleared and its byte stored.
- R2: A lane whose byte enable `wr_be_i[i]` is low keeps both its flag and its stored byte across the write.
- R3: A read issued with `rd_en_i` in one cycle produces `rd_valid_o` high in the next cycle. In that cycle `rd_drv_o[i]` is the inverse of lane i's flag, a flagged lane reads as zero, and a driven lane carries its stored (nonzero) byte.
- R4: A write adds no wait cycle: a read of the same address issued in the cycle right after the write returns the new contents.
- R5: In a cycle that follows a cycle without `rd_en_i`, `rd_valid_o` is low and `rd_data_o` and `rd_drv_o` are zero.
- R6: Reset sets every flag, so any word read before it is written returns zero with no lane driven.
- R7: `wr_skip_cnt_o` grows by the number of enabled all-zero lanes in each write, visible in the cycle after the write.
- R8: `rd_skip_cnt_o` grows by the number of flagged lanes in each read, visible in the same cycle as that read's `rd_valid_o`.
- R9: Both counters saturate at all ones and never wrap.
- R10: Reset clears both counters to zero.
- R11: When a read and a write hit the same address in one cycle, the read returns the flags and data as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | $clog2(DEPTH) | Write word address |
| wr_data_i | input | 32 | Write data, lane i in bits 8i+7..8i |
| wr_be_i | input | 4 | Per-lane write enables |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | $clog2(DEPTH) | Read word address |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 32 | Read data, flagged lanes zero |
| rd_drv_o | output | 4 | Per-lane bus drive enable |
| wr_skip_cnt_o | output | CNT_W | Suppressed byte writes, saturating |
| rd_skip_cnt_o | output | CNT_W | Suppressed byte reads, saturating |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle read latency and the idle quiet state;
- that every driven lane carries a nonzero byte and every undriven lane carries zero;
- that the drive mask matches the gate mask taken at read time;
- that the counters never wrap and hold once saturated.

Other behaviours depend on history and can only be shown by the bench's scenarios. These are the effect of partial byte enables on earlier contents, the read-before-write result on an address collision, the flag state after reset, and the exact counter increments.

// File: rtl/zgs_pkg.sv
package zgs_pkg;

    localparam int unsigned LANE_W    = 8;
    localparam int unsigned LANES     = 4;
    localparam int unsigned WORD_W    = LANE_W * LANES;
    localparam int unsigned CNT_INC_W = $clog2(LANES + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;
    typedef logic [CNT_INC_W-1:0] lane_cnt_t;

    // One registered read result
    typedef struct packed {
        logic  valid;
        word_t data;
        lane_t drv;
    } rd_beat_t;

    // Mask of lanes whose byte holds at least one set bit
    function automatic lane_t lane_nonzero(input word_t w);
        lane_t m;
        for (int l = 0; l < int'(LANES); l++) begin
            m[l] = |w[l*LANE_W +: LANE_W];
        end
        return m;
    endfunction

    function automatic lane_cnt_t lane_popcount(input lane_t m);
        lane_cnt_t c;
        c = '0;
        for (int l = 0; l < int'(LANES); l++) begin
            c = c + lane_cnt_t'(m[l]);
        end
        return c;
    endfunction

endpackage

// File: rtl/zgs_zero_detect.sv
module zgs_zero_detect
    import zgs_pkg::*;
(
    input  word_t data_i,
    output lane_t zero_o
);

    // One all-zero detector per lane, working in parallel with address decode
    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        assign zero_o[g] = ~|data_i[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zgs_sat_counter.sv
module zgs_sat_counter #(
    parameter int unsigned W     = 32,
    parameter int unsigned INC_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [INC_W-1:0] inc_i,
    output logic [W-1:0]     cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + (W+1)'(inc_i);
        cnt_d = sum[W] ? '1 : sum[W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q >= $past(cnt_q)); // R9
    AST_CNT_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == '1) |=> (cnt_q == '1)); // R9
    AST_CNT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i == '0) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/zgs_bank.sv
module zgs_bank
    import zgs_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  word_t         wr_data_i,
    input  lane_t         wr_be_i,
    input  lane_t         wr_zero_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output lane_t         rd_gate_o,
    output rd_beat_t      rd_beat_o
);

    // Flags reset to "all zero"; data cells carry no reset
    lane_t    flag_d [DEPTH];
    lane_t    flag_q [DEPTH];
    word_t    mem_d  [DEPTH];
    word_t    mem_q  [DEPTH];
    rd_beat_t beat_d, beat_q;
    lane_t    rd_flag;

    always_comb begin
        flag_d = flag_q;
        mem_d  = mem_q;

        // Read path sees state before any same-cycle write
        rd_flag      = flag_q[rd_addr_i];
        beat_d       = '0;
        beat_d.valid = rd_en_i;
        if (rd_en_i) begin
            beat_d.drv = ~rd_flag;
            for (int l = 0; l < int'(LANES); l++) begin
                if (!rd_flag[l]) begin
                    beat_d.data[l*LANE_W +: LANE_W] = mem_q[rd_addr_i][l*LANE_W +: LANE_W];
                end
            end
        end

        // Write path: flag always updated for enabled lanes, cell only when nonzero
        if (wr_en_i) begin
            for (int l = 0; l < int'(LANES); l++) begin
                if (wr_be_i[l]) begin
                    flag_d[wr_addr_i][l] = wr_zero_i[l];
                    if (!wr_zero_i[l]) begin
                        mem_d[wr_addr_i][l*LANE_W +: LANE_W] = wr_data_i[l*LANE_W +: LANE_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                flag_q[i] <= '1;
            end
            beat_q <= '0;
        end else begin
            flag_q <= flag_d;
            beat_q <= beat_d;
        end
        mem_q <= mem_d;
    end

    assign rd_gate_o = rd_en_i ? rd_flag : '0;
    assign rd_beat_o = beat_q;

    AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> beat_q.valid); // R3
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (!beat_q.valid && beat_q.drv == '0 && beat_q.data == '0)); // R5
    AST_DRIVEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (beat_q.drv & ~lane_nonzero(beat_q.data)) == '0); // R1
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (~beat_q.drv & lane_nonzero(beat_q.data)) == '0); // R3
    AST_DRV_MATCHES_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> (beat_q.drv == ~$past(rd_gate_o))); // R8

endmodule

// File: rtl/zero_gated_word_store.sv
module zero_gated_word_store
    import zgs_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CNT_W = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [LANES-1:0]  wr_be_i,
    input  logic              rd_en_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [LANES-1:0]  rd_drv_o,
    output logic [CNT_W-1:0]  wr_skip_cnt_o,
    output logic [CNT_W-1:0]  rd_skip_cnt_o
);

    lane_t     wr_zero;
    lane_t     rd_gate;
    rd_beat_t  beat;
    lane_cnt_t wr_skip_inc;
    lane_cnt_t rd_skip_inc;

    zgs_zero_detect u_detect (
        .data_i (wr_data_i),
        .zero_o (wr_zero)
    );

    zgs_bank #(.DEPTH(DEPTH)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .wr_be_i   (wr_be_i),
        .wr_zero_i (wr_zero),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rd_gate_o (rd_gate),
        .rd_beat_o (beat)
    );

    always_comb begin
        wr_skip_inc = wr_en_i ? lane_popcount(wr_be_i & wr_zero) : '0;
        rd_skip_inc = lane_popcount(rd_gate);
    end

    zgs_sat_counter #(.W(CNT_W), .INC_W(CNT_INC_W)) u_wr_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (wr_skip_inc),
        .cnt_o  (wr_skip_cnt_o)
    );

    zgs_sat_counter #(.W(CNT_W), .INC_W(CNT_INC_W)) u_rd_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (rd_skip_inc),
        .cnt_o  (rd_skip_cnt_o)
    );

    assign rd_valid_o = beat.valid;
    assign rd_data_o  = beat.data;
    assign rd_drv_o   = beat.drv;

    AST_WR_CNT_NONZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_be_i & wr_zero) == '0) |=> $stable(wr_skip_cnt_o)); // R7
    AST_RD_CNT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_skip_cnt_o)); // R8
    AST_NO_WRITE_NO_WCNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(wr_skip_cnt_o)); // R7

endmodule

// File: tb/zero_gated_word_store_tb_top.sv
module zero_gated_word_store_tb_top;

    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int CNT_W = 6;
    localparam int CMAX  = 63;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [31:0]   data;
        logic [3:0]    be;
        logic [31:0]   exp_data;
        logic [3:0]    exp_drv;
    } vec_t;

    // Applied in order; each row is a write then a read of the same word
    localparam vec_t VEC [9] = '{
        '{4'd1,  32'h11223344, 4'b1111, 32'h11223344, 4'b1111}, // R1 all nonzero
        '{4'd1,  32'h00ff0000, 4'b1111, 32'h00ff0000, 4'b0100}, // R1 three zero lanes
        '{4'd1,  32'hAA000000, 4'b1000, 32'hAAff0000, 4'b1100}, // R2 partial enable
        '{4'd1,  32'h00000055, 4'b0011, 32'hAAff0055, 4'b1101}, // R2 low lanes only
        '{4'd2,  32'h00000000, 4'b1111, 32'h00000000, 4'b0000}, // R1 all zero word
        '{4'd2,  32'h01000080, 4'b0000, 32'h00000000, 4'b0000}, // R2 no lanes enabled
        '{4'd15, 32'h80808080, 4'b1111, 32'h80808080, 4'b1111}, // R4 top address
        '{4'd0,  32'h00000001, 4'b1111, 32'h00000001, 4'b0001}, // R4 bottom address
        '{4'd1,  32'h00000000, 4'b1000, 32'h00ff0055, 4'b0101}  // R1 gated lane clears
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [31:0]       wr_data;
    logic [3:0]        wr_be;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic [3:0]        rd_drv;
    logic [CNT_W-1:0]  wr_cnt;
    logic [CNT_W-1:0]  rd_cnt;

    int checks = 0;
    int fails  = 0;
    int exp_wr = 0;
    int exp_rd = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    zero_gated_word_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .wr_be_i       (wr_be),
        .rd_en_i       (rd_en),
        .rd_addr_i     (rd_addr),
        .rd_valid_o    (rd_valid),
        .rd_data_o     (rd_data),
        .rd_drv_o      (rd_drv),
        .wr_skip_cnt_o (wr_cnt),
        .rd_skip_cnt_o (rd_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int zero_lanes(input logic [31:0] d, input logic [3:0] be);
        int n = 0;
        for (int l = 0; l < 4; l++) if (be[l] && d[l*8 +: 8] == 8'h00) n++;
        return n;
    endfunction

    function automatic int sat_add(input int a, input int b);
        return (a + b > CMAX) ? CMAX : a + b;
    endfunction

    // Entered and left at a falling edge
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0;
        exp_wr = sat_add(exp_wr, zero_lanes(d, be));
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; wr_data = '0; wr_be = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_wr = 0;
        exp_rd = 0;
    endtask

    initial begin
        do_reset();
        check("R10 wr counter after reset", 32'(wr_cnt), 32'd0);
        check("R10 rd counter after reset", 32'(rd_cnt), 32'd0);
        check("R5 valid low after reset", 32'(rd_valid), 32'd0);

        do_read(4'd5);
        exp_rd = sat_add(exp_rd, 4);
        check("R6 unwritten word data", rd_data, 32'd0);
        check("R6 unwritten word drive", 32'(rd_drv), 32'd0);
        check("R8 rd counter on unwritten read", 32'(rd_cnt), 32'(exp_rd));

        for (int i = 0; i < 9; i++) begin
            do_write(VEC[i].addr, VEC[i].data, VEC[i].be);
            check("R7 wr counter after write", 32'(wr_cnt), 32'(exp_wr));
            do_read(VEC[i].addr);
            exp_rd = sat_add(exp_rd, 4 - $countones(VEC[i].exp_drv));
            check("R3 read valid", 32'(rd_valid), 32'd1);
            check("R4 R1 R2 read data", rd_data, VEC[i].exp_data);
            check("R3 lane drive", 32'(rd_drv), 32'(VEC[i].exp_drv));
            check("R8 rd counter after read", 32'(rd_cnt), 32'(exp_rd));
        end

        @(negedge clk);
        check("R5 valid idle", 32'(rd_valid), 32'd0);
        check("R5 data idle", rd_data, 32'd0);
        check("R5 drive idle", 32'(rd_drv), 32'd0);

        // R11 read and write to one address in the same cycle
        do_write(4'd3, 32'hDEADBEEF, 4'b1111);
        wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h0; wr_be = 4'b1111;
        rd_en = 1'b1; rd_addr = 4'd3;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        exp_wr = sat_add(exp_wr, 4);
        check("R11 collision returns old data", rd_data, 32'hDEADBEEF);
        check("R11 collision returns old drive", 32'(rd_drv), 32'hF);
        check("R7 wr counter after collision", 32'(wr_cnt), 32'(exp_wr));
        do_read(4'd3);
        exp_rd = sat_add(exp_rd, 4);
        check("R11 new data after collision", rd_data, 32'd0);
        check("R11 new drive after collision", 32'(rd_drv), 32'd0);

        // R9 saturation of both counters
        for (int i = 0; i < 20; i++) do_write(4'd4, 32'h0, 4'b1111);
        check("R9 wr counter saturated", 32'(wr_cnt), 32'(CMAX));
        for (int i = 0; i < 20; i++) do_read(4'd4);
        @(negedge clk);
        check("R9 rd counter saturated", 32'(rd_cnt), 32'(CMAX));

        // R10 R6 reset in mid-run
        do_reset();
        check("R10 wr counter cleared", 32'(wr_cnt), 32'd0);
        check("R10 rd counter cleared", 32'(rd_cnt), 32'd0);
        do_read(4'd1);
        check("R6 flags set after reset data", rd_data, 32'd0);
        check("R6 flags set after reset drive", 32'(rd_drv), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule